// File: doc/BRIEF.md
# Calibrated Fractional Second Prescaler

This block turns a slow oscillator-rate enable pulse into a strobe that fires once per second. A 21-bit calibration word sets the length of each second. Its low part is an integer tick count. A small fractional field, together with an enable bit, lengthens some seconds in every group of sixteen by a single tick. Spreading that extra tick across the group trims out the crystal's frequency error, with a resolution of one sixteenth of a tick per second.

Software loads a new calibration word through a single write strobe. Each write clears the running tick count and restarts the sixteen-second correction cycle. The strobe that follows a write therefore comes a whole second after it. The current tick position can be read at all times as a 16-bit value. The seconds counter that uses the strobe and the oscillator that supplies the enable lie outside this block.

Top module: `cal_sec_prescaler`

## Requirements
- R1: Synchronous reset drives `sec_strobe` and `tick_count` to 0, clears the correction position and loads the calibration word 0x198233. In that word, bits 15:0 are the integer count (33331), bits 19:16 are the fraction (9) and bit 20 is the fraction enable (1). The first second after reset is therefore 33333 enabled ticks long.
- R2: `tick_count` starts at 0 and rises by one on each enabled tick until it equals the integer count. It never exceeds the integer count, and it holds its value on cycles where `osc_tick_en` is low.
- R3: `sec_strobe` is high for exactly one clock cycle, the cycle after the enabled tick that completes a second. At that same edge `tick_count` returns to 0. `sec_strobe` is never high without an enabled tick in the previous cycle.
- R4: With the enable bit (20) clear, every second lasts exactly the integer count plus one enabled ticks.
- R5: With the enable bit set, seconds are numbered 0 to 15 and wrap around. Seconds whose number is below the fractional field (bits 19:16) last one extra tick, and the others last the integer count plus one ticks. During the extra tick, `tick_count` holds at the integer count.
- R6: A calibration write sets `tick_count` to 0, cancels any pending strobe, restarts the second numbering at 0 and ignores any tick in the same cycle. The next strobe comes one full period, under the new word, after the write.
- R7: A fractional field of 0 with the enable bit set gives no extra ticks. A field of 15 lengthens fifteen of every sixteen seconds.
- R8: An integer count of 0 with the enable bit clear produces a strobe after every enabled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick_en | input | 1 | One-cycle enable at the oscillator rate |
| cal_wr | input | 1 | Calibration write strobe |
| cal_data | input | 21 | Calibration word: integer 15:0, fraction 19:16, enable 20 |
| sec_strobe | output | 1 | One-cycle pulse per completed second |
| tick_count | output | 16 | Current tick position within the second |

## Verification
The hardest case to reach is the wrap of the sixteen-second correction cycle under a non-trivial fraction. Checking it means watching the same second number come round twice, and at the default word that takes far too long. The bench therefore writes short integer counts with fractions of 2, 0 and 15 and measures seventeen or more consecutive periods, so the lengthened seconds are seen to stop and then start again after the wrap. A calibration write made mid-second while ticks are active covers the restart and the discarded same-cycle tick. The full default second after reset is measured once.

// File: rtl/cal_prescale_pkg.sv
package cal_prescale_pkg;

    localparam int INT_W  = 16;
    localparam int FRAC_W = 4;
    localparam int CAL_W  = INT_W + FRAC_W + 1;
    localparam int SLOTS  = 1 << FRAC_W;

    localparam logic [CAL_W-1:0] CAL_RESET = 21'h198233;

    typedef struct packed {
        logic              frac_on;
        logic [FRAC_W-1:0] frac_n;
        logic [INT_W-1:0]  whole;
    } cal_t;

    typedef struct packed {
        logic [INT_W-1:0] cnt;
        logic             bonus;
    } div_state_t;

    function automatic cal_t decode_cal(input logic [CAL_W-1:0] w);
        return cal_t'(w);
    endfunction

    function automatic logic extra_for_slot(input cal_t c, input logic [FRAC_W-1:0] slot);
        return c.frac_on && (slot < c.frac_n);
    endfunction

endpackage

// File: rtl/cal_word_reg.sv
module cal_word_reg
    import cal_prescale_pkg::*;
#(
    parameter logic [CAL_W-1:0] RESET_WORD = CAL_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CAL_W-1:0] wr_data,
    output cal_t             cfg
);

    logic [CAL_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)        word_q <= RESET_WORD;
        else if (wr_en) word_q <= wr_data;
    end

    assign cfg = decode_cal(word_q);

    assert_reg_loads_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (word_q == $past(wr_data)));

endmodule

// File: rtl/frac_sequencer.sv
module frac_sequencer
    import cal_prescale_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic advance,
    input  cal_t cfg,
    output logic extra_due
);

    logic [FRAC_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst || restart) slot_q <= '0;
        else if (advance)   slot_q <= slot_q + 1'b1;
    end

    assign extra_due = extra_for_slot(cfg, slot_q);

    assert_slot_step_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && !restart) |=> (slot_q == $past(slot_q) + 1'b1));

    assert_slot_restart_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (slot_q == '0));

endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import cal_prescale_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick_en,
    input  logic [INT_W-1:0] whole,
    input  logic             extra_due,
    output logic             wrap,
    output logic             strobe,
    output logic [INT_W-1:0] count
);

    div_state_t st_q, st_d;
    logic       at_end;

    assign at_end = (st_q.cnt == whole);
    assign wrap   = tick_en && !restart && at_end && (!extra_due || st_q.bonus);

    always_comb begin
        st_d = st_q;
        if (tick_en) begin
            if (!at_end) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (extra_due && !st_q.bonus) begin
                st_d.bonus = 1'b1;
            end else begin
                st_d.cnt   = '0;
                st_d.bonus = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st_q   <= '0;
            strobe <= 1'b0;
        end else begin
            st_q   <= st_d;
            strobe <= wrap;
        end
    end

    assign count = st_q.cnt;

    assert_strobe_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(tick_en && !restart));

    assert_bonus_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.bonus |-> at_end);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !restart) |=> ($stable(st_q.cnt) && !strobe));

endmodule

// File: rtl/cal_sec_prescaler.sv
module cal_sec_prescaler
    import cal_prescale_pkg::*;
#(
    parameter logic [CAL_W-1:0] RESET_WORD = CAL_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick_en,
    input  logic             cal_wr,
    input  logic [CAL_W-1:0] cal_data,
    output logic             sec_strobe,
    output logic [INT_W-1:0] tick_count
);

    cal_t cfg;
    logic extra_due;
    logic wrap;

    cal_word_reg #(.RESET_WORD(RESET_WORD)) u_cal (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cal_wr),
        .wr_data (cal_data),
        .cfg     (cfg)
    );

    frac_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .restart   (cal_wr),
        .advance   (wrap),
        .cfg       (cfg),
        .extra_due (extra_due)
    );

    tick_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (cal_wr),
        .tick_en   (osc_tick_en),
        .whole     (cfg.whole),
        .extra_due (extra_due),
        .wrap      (wrap),
        .strobe    (sec_strobe),
        .count     (tick_count)
    );

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        tick_count <= cfg.whole);

    assert_write_clears_R6: assert property (@(posedge clk) disable iff (rst)
        cal_wr |=> (tick_count == '0 && !sec_strobe));

    assert_strobe_zeroes_R3: assert property (@(posedge clk) disable iff (rst)
        sec_strobe |-> (tick_count == '0));

endmodule

// File: tb/tb_cal_sec_prescaler.sv
module tb_cal_sec_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick_en = 1'b0;
    logic        cal_wr = 1'b0;
    logic [20:0] cal_data = '0;
    logic        sec_strobe;
    logic [15:0] tick_count;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";
    bit compare_on = 1'b0;

    // reference model state (behavioural)
    int m_whole = 33331, m_frac = 9, m_on = 1;
    int m_ticks = 0, m_sec = 0, m_strobe = 0;

    cal_sec_prescaler dut (
        .clk(clk), .rst(rst), .osc_tick_en(osc_tick_en), .cal_wr(cal_wr),
        .cal_data(cal_data), .sec_strobe(sec_strobe), .tick_count(tick_count)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int period_now();
        return m_whole + 1 + ((m_on != 0 && m_sec < m_frac) ? 1 : 0);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_whole = 33331; m_frac = 9; m_on = 1;
            m_ticks = 0; m_sec = 0; m_strobe = 0;
        end else if (cal_wr) begin
            m_whole = int'(cal_data[15:0]);
            m_frac  = int'(cal_data[19:16]);
            m_on    = int'(cal_data[20]);
            m_ticks = 0; m_sec = 0; m_strobe = 0;
        end else if (osc_tick_en) begin
            m_ticks++;
            if (m_ticks == period_now()) begin
                m_strobe = 1; m_ticks = 0; m_sec = (m_sec + 1) % 16;
            end else begin
                m_strobe = 0;
            end
        end else begin
            m_strobe = 0;
        end
    end

    always @(negedge clk) begin
        if (compare_on && !rst) begin
            int exp_tc;
            exp_tc = (m_ticks > m_whole) ? m_whole : m_ticks;
            check(int'(sec_strobe) == m_strobe, tag, "strobe", int'(sec_strobe), m_strobe);
            check(int'(tick_count) == exp_tc, tag, "tick_count", int'(tick_count), exp_tc);
        end
    end

    always @(posedge clk) begin
        if (cycles == 190000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic write_cal(input logic [20:0] w);
        cal_data = w;
        cal_wr = 1'b1;
        @(negedge clk);
        cal_wr = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sec_strobe && n < 100000);
    endtask

    task automatic expect_periods(input string req, input int count, input int whole,
                                  input int frac, input int on);
        for (int k = 0; k < count; k++) begin
            int got, want;
            want = whole + 1 + ((on != 0 && (k % 16) < frac) ? 1 : 0);
            measure(got);
            check(got == want, req, "period", got, want);
        end
    endtask

    initial begin
        int got;
        repeat (3) @(negedge clk);
        check(sec_strobe == 1'b0, "R1", "reset strobe", int'(sec_strobe), 0);
        check(tick_count == 16'd0, "R1", "reset tick_count", int'(tick_count), 0);
        compare_on = 1'b1;

        // R1: default word, first second is 33331+1+1 ticks
        rst = 1'b0;
        osc_tick_en = 1'b1;
        measure(got);
        check(got == 33333, "R1", "default first period", got, 33333);

        // R2: irregular enable pattern, integer 5
        tag = "R2";
        write_cal(21'h000005);
        for (int i = 0; i < 40; i++) begin
            osc_tick_en = ((i % 3) != 1);
            @(negedge clk);
        end
        osc_tick_en = 1'b0;
        repeat (4) @(negedge clk);
        check(tick_count <= 16'd5, "R2", "held bounded", int'(tick_count), 5);

        // R4 and R3: fraction disabled, periods of 6, strobe one cycle wide
        tag = "R4";
        osc_tick_en = 1'b1;
        write_cal({1'b0, 4'd7, 16'd5});
        expect_periods("R4", 3, 5, 7, 0);
        @(negedge clk);
        check(sec_strobe == 1'b0, "R3", "strobe width", int'(sec_strobe), 0);

        // R5: fraction 2 on integer 3, 18 periods across the wrap
        tag = "R5";
        write_cal({1'b1, 4'd2, 16'd3});
        expect_periods("R5", 18, 3, 2, 1);

        // R7: fraction 0 and fraction 15
        tag = "R7";
        write_cal({1'b1, 4'd0, 16'd4});
        expect_periods("R7", 17, 4, 0, 1);
        write_cal({1'b1, 4'd15, 16'd2});
        expect_periods("R7", 17, 2, 15, 1);

        // R8: integer 0 strobes every tick
        tag = "R8";
        write_cal(21'h000000);
        expect_periods("R8", 5, 0, 0, 0);
        check(sec_strobe == 1'b1, "R8", "strobe each tick", int'(sec_strobe), 1);

        // R6: mid-second rewrite with ticks running, then full period
        tag = "R6";
        write_cal({1'b1, 4'd3, 16'd9});
        repeat (6) @(negedge clk);
        write_cal({1'b1, 4'd3, 16'd9});
        check(tick_count == 16'd0, "R6", "cleared after write", int'(tick_count), 0);
        expect_periods("R6", 4, 9, 3, 1);
        repeat (4) @(negedge clk);
        write_cal({1'b0, 4'd0, 16'd7});
        measure(got);
        check(got == 8, "R6", "period after write", got, 8);

        osc_tick_en = 1'b0;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule